// File: doc/BRIEF.md
# Half-Duplex Backpressure Carrier Generator

This block applies backpressure on a half-duplex link. While the receive side of the port is congested, it holds the wire busy by driving preamble, so that the other stations on the segment sense carrier and defer. The congestion request arrives from the same logic that decides when to send pause frames on a full-duplex link. The block therefore turns on and off at the same points as that flow control, and it adds no hysteresis of its own. The carrier is not held without a break. After a programmable number of bit times it is dropped for a short programmable silent gap and then raised again. This keeps the link below the jabber limit and keeps the other stations clear of excessive-deferral faults, while the gap is too short for any of them to start a frame.

The local transmitter has priority over the jam. When it has a frame pending, the carrier is released and a grant is given. When the queue empties and congestion persists, the jam resumes with a fresh window. A collision under congestion does not start exponential backoff. The carrier is raised again on the next cycle. The block is active only when the port is in half-duplex mode and backpressure is enabled. Otherwise it sits idle, with the carrier off and the grant high. One clock cycle counts as one bit time.

Top module: `hdbp_carrier_gen`

## Requirements
- R1: In the first cycle after a synchronous reset, `carrier_o` is 0 and `tx_grant_o` is 1.
- R2: If `half_duplex_i` or `bp_enable_i` is 0, then one cycle later `carrier_o` is 0 and `tx_grant_o` is 1, whatever the other inputs are.
- R3: When the block is enabled and idle, and `congest_i` rises with no frame pending and no collision, `carrier_o` goes to 1 and `tx_grant_o` goes to 0 on the next cycle.
- R4: Without collisions or pending frames, one carrier burst lasts exactly N cycles, where N is the effective value of `carrier_len_i`.
- R5: Each carrier burst is followed by exactly M cycles with `carrier_o` at 0 and `tx_grant_o` at 0, where M is the effective value of `gap_len_i`. After those M cycles the carrier rises again.
- R6: A length input of 0 selects a default. The carrier default is 16000 bit times, below the jabber limit. The gap default is 48 bit times, shorter than one interframe gap.
- R7: With the block enabled and congested, `tx_pending_i` at 1 and no collision give `tx_grant_o` at 1 and `carrier_o` at 0 on the next cycle. This holds in every state, including during a burst or a gap.
- R8: When the grant is held under congestion and `tx_pending_i` falls with no collision, `carrier_o` rises on the next cycle and starts a full N-cycle burst.
- R9: A collision seen while the block is enabled and congested raises `carrier_o` on the next cycle, even if a frame is pending. It then starts a new full N-cycle burst, and during a burst it restarts the window.
- R10: When `congest_i` is 0 and the block is enabled, then one cycle later `carrier_o` is 0 and `tx_grant_o` is 1, and a collision has no effect on either.
- R11: `carrier_o` and `tx_grant_o` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per bit time |
| rst | input | 1 | Synchronous active-high reset |
| half_duplex_i | input | 1 | Port is in half-duplex mode |
| bp_enable_i | input | 1 | Backpressure enabled |
| congest_i | input | 1 | Receive congestion request |
| tx_pending_i | input | 1 | Local transmitter has a frame waiting |
| collision_i | input | 1 | Collision detected on the wire |
| carrier_len_i | input | CAR_W (16) | Burst length in bit times, 0 selects default |
| gap_len_i | input | GAP_W (8) | Silent gap in bit times, 0 selects default |
| carrier_o | output | 1 | Drive preamble on the wire |
| tx_grant_o | output | 1 | Local transmitter may send |

## Verification
A wrong state shows within one cycle, because both outputs are decoded straight from the state register. A stuck jam or a missed release appears as `carrier_o` high one cycle after congestion drops or a frame becomes pending. A lost collision response shows as a silent cycle where carrier was due. A wrong timer state does not show until the end of a window: a burst or gap one cycle too long or too short is seen N or M cycles after the window began. For that reason the bench measures complete runs rather than single samples.

// File: rtl/hdbp_pkg.sv
package hdbp_pkg;

    // Defaults applied when a length input is programmed to zero (bit times)
    localparam int unsigned DEF_CARRIER_BITS = 16000;
    localparam int unsigned DEF_GAP_BITS     = 48;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_JAM   = 2'd1,
        ST_GAP   = 2'd2,
        ST_LOCAL = 2'd3
    } hdbp_state_e;

    typedef struct packed {
        logic en;       // block enabled
        logic congest;  // congestion request
        logic pending;  // local frame waiting
        logic coll;     // collision seen
    } hdbp_evt_t;

    typedef struct packed {
        logic ld_car;   // (re)start carrier window
        logic ld_gap;   // start silent gap
    } hdbp_cmd_t;

    // Wire is held by this block in these states
    function automatic logic holds_wire(hdbp_state_e s);
        return (s == ST_JAM) || (s == ST_GAP);
    endfunction

endpackage

// File: rtl/hdbp_len_sel.sv
module hdbp_len_sel #(
    parameter int unsigned W   = 16,
    parameter int unsigned DEF = 1
) (
    input  logic [W-1:0] len_i,
    output logic [W-1:0] eff_o
);
    localparam logic [W-1:0] DEF_V = W'(DEF);

    // Zero picks the default; the default itself is never zero
    generate
        if (DEF == 0) begin : g_nodef
            assign eff_o = (len_i == '0) ? W'(1) : len_i;
        end else begin : g_def
            assign eff_o = (len_i == '0) ? DEF_V : len_i;
        end
    endgenerate
endmodule

// File: rtl/hdbp_win_timer.sv
module hdbp_win_timer #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] len_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_q;

    // A window of len cycles: loaded with len-1, expires when it reads zero
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= len_i - W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/hdbp_ctrl.sv
module hdbp_ctrl
    import hdbp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  hdbp_evt_t   evt_i,
    input  logic        car_exp_i,
    input  logic        gap_exp_i,
    output hdbp_state_e state_o,
    output hdbp_cmd_t   cmd_o
);
    hdbp_state_e state_q, state_d;
    logic        coll_hit;

    assign coll_hit = evt_i.en && evt_i.congest && evt_i.coll;

    always_comb begin
        state_d = state_q;
        if (!evt_i.en || !evt_i.congest) begin
            state_d = ST_IDLE;
        end else if (evt_i.coll) begin
            state_d = ST_JAM;          // no backoff: carrier at once
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = evt_i.pending ? ST_LOCAL : ST_JAM;
                ST_JAM: begin
                    if (evt_i.pending)  state_d = ST_LOCAL;
                    else if (car_exp_i) state_d = ST_GAP;
                end
                ST_GAP: begin
                    if (evt_i.pending)  state_d = ST_LOCAL;
                    else if (gap_exp_i) state_d = ST_JAM;
                end
                ST_LOCAL: state_d = evt_i.pending ? ST_LOCAL : ST_JAM;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd_o.ld_car = (state_d == ST_JAM) && ((state_q != ST_JAM) || coll_hit);
        cmd_o.ld_gap = (state_d == ST_GAP) && (state_q != ST_GAP);
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign state_o = state_q;
endmodule

// File: rtl/hdbp_carrier_gen.sv
module hdbp_carrier_gen
    import hdbp_pkg::*;
#(
    parameter int unsigned CAR_W = 16,
    parameter int unsigned GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             half_duplex_i,
    input  logic             bp_enable_i,
    input  logic             congest_i,
    input  logic             tx_pending_i,
    input  logic             collision_i,
    input  logic [CAR_W-1:0] carrier_len_i,
    input  logic [GAP_W-1:0] gap_len_i,
    output logic             carrier_o,
    output logic             tx_grant_o
);
    hdbp_evt_t        evt;
    hdbp_cmd_t        cmd;
    hdbp_state_e      state;
    logic [CAR_W-1:0] car_eff;
    logic [GAP_W-1:0] gap_eff;
    logic             car_exp, gap_exp;

    assign evt.en      = half_duplex_i && bp_enable_i;
    assign evt.congest = congest_i;
    assign evt.pending = tx_pending_i;
    assign evt.coll    = collision_i;

    hdbp_len_sel #(.W(CAR_W), .DEF(DEF_CARRIER_BITS)) u_car_sel (
        .len_i (carrier_len_i),
        .eff_o (car_eff)
    );

    hdbp_len_sel #(.W(GAP_W), .DEF(DEF_GAP_BITS)) u_gap_sel (
        .len_i (gap_len_i),
        .eff_o (gap_eff)
    );

    hdbp_win_timer #(.W(CAR_W)) u_car_tmr (
        .clk       (clk),
        .rst       (rst),
        .load_i    (cmd.ld_car),
        .len_i     (car_eff),
        .expired_o (car_exp)
    );

    hdbp_win_timer #(.W(GAP_W)) u_gap_tmr (
        .clk       (clk),
        .rst       (rst),
        .load_i    (cmd.ld_gap),
        .len_i     (gap_eff),
        .expired_o (gap_exp)
    );

    hdbp_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .evt_i     (evt),
        .car_exp_i (car_exp),
        .gap_exp_i (gap_exp),
        .state_o   (state),
        .cmd_o     (cmd)
    );

    assign carrier_o  = (state == ST_JAM);
    assign tx_grant_o = !holds_wire(state);
endmodule

// File: rtl/hdbp_carrier_gen_chk.sv
module hdbp_carrier_gen_chk
    import hdbp_pkg::*;
#(
    parameter int unsigned CAR_W = 16,
    parameter int unsigned GAP_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             half_duplex_i,
    input logic             bp_enable_i,
    input logic             congest_i,
    input logic             tx_pending_i,
    input logic             collision_i,
    input logic [CAR_W-1:0] carrier_len_i,
    input logic [GAP_W-1:0] gap_len_i,
    input logic             carrier_o,
    input logic             tx_grant_o
);
    logic        en, hit_q, car_q;
    logic [31:0] run_q, run_now, lim;

    assign en  = half_duplex_i && bp_enable_i;
    assign lim = (carrier_len_i == '0) ? DEF_CARRIER_BITS : 32'(carrier_len_i);

    // Length of the current carrier run since its last (re)start
    always_comb begin
        if (!carrier_o)          run_now = '0;
        else if (hit_q || !car_q) run_now = 32'd1;
        else                      run_now = run_q + 32'd1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
            car_q <= 1'b0;
            hit_q <= 1'b0;
        end else begin
            run_q <= run_now;
            car_q <= carrier_o;
            hit_q <= en && congest_i && collision_i;
        end
    end

    AST_OUT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(carrier_o && tx_grant_o)); // R11
    AST_GATE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!carrier_o && tx_grant_o)); // R2
    AST_START_JAM: assert property (@(posedge clk) disable iff (rst)
        (en && congest_i && tx_grant_o && !tx_pending_i && !collision_i) |=> carrier_o); // R8
    AST_LOCAL_FIRST: assert property (@(posedge clk) disable iff (rst)
        (en && congest_i && tx_pending_i && !collision_i) |=> (tx_grant_o && !carrier_o)); // R7
    AST_COLL_JAM: assert property (@(posedge clk) disable iff (rst)
        (en && congest_i && collision_i) |=> carrier_o); // R9
    AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (en && !congest_i) |=> (!carrier_o && tx_grant_o)); // R10
    AST_RUN_LIMIT: assert property (@(posedge clk) disable iff (rst)
        run_now <= lim); // R4
endmodule

bind hdbp_carrier_gen hdbp_carrier_gen_chk #(.CAR_W(CAR_W), .GAP_W(GAP_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .half_duplex_i (half_duplex_i),
    .bp_enable_i   (bp_enable_i),
    .congest_i     (congest_i),
    .tx_pending_i  (tx_pending_i),
    .collision_i   (collision_i),
    .carrier_len_i (carrier_len_i),
    .gap_len_i     (gap_len_i),
    .carrier_o     (carrier_o),
    .tx_grant_o    (tx_grant_o)
);

// File: tb/hdbp_carrier_gen_test.sv
module hdbp_carrier_gen_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hd = 1'b0, bpen = 1'b0, cong = 1'b0, pend = 1'b0, coll = 1'b0;
    logic [15:0] clen = 16'd3;
    logic [7:0]  glen = 8'd2;
    logic        carrier_o, tx_grant_o;
    int          applied = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    hdbp_carrier_gen uut (
        .clk           (clk),
        .rst           (rst),
        .half_duplex_i (hd),
        .bp_enable_i   (bpen),
        .congest_i     (cong),
        .tx_pending_i  (pend),
        .collision_i   (coll),
        .carrier_len_i (clen),
        .gap_len_i     (glen),
        .carrier_o     (carrier_o),
        .tx_grant_o    (tx_grant_o)
    );

    // {hd, bpen, congest, pending, collision, exp_carrier, exp_grant}
    // burst 3, gap 2; each row's result is sampled after the next edge
    localparam logic [6:0] VEC [25] = '{
        7'b11000_01, 7'b11100_10, 7'b11100_10, 7'b11100_10, 7'b11100_00,
        7'b11100_00, 7'b11100_10, 7'b11110_01, 7'b11110_01, 7'b11111_10,
        7'b11100_10, 7'b11101_10, 7'b11100_10, 7'b11100_10, 7'b11100_00,
        7'b11101_10, 7'b11000_01, 7'b11001_01, 7'b11110_01, 7'b11100_10,
        7'b10100_01, 7'b01100_01, 7'b11100_10, 7'b11010_01, 7'b11000_01
    };
    localparam int VREQ [25] = '{
        10, 3, 4, 4, 5, 5, 5, 7, 7, 9, 9, 9, 4, 4, 4, 9, 10, 10, 7, 8, 2, 2, 3, 10, 10
    };

    function automatic string rtag(int n);
        case (n)
            1: return "R1";   2: return "R2";   3: return "R3";
            4: return "R4";   5: return "R5";   6: return "R6";
            7: return "R7";   8: return "R8";   9: return "R9";
            10: return "R10"; default: return "R11";
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        applied++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        check("R11", int'(carrier_o && tx_grant_o), 0);
    endtask

    // Start congestion from idle and measure one burst and the gap after it
    task automatic measure(string tag, int exp_car, int exp_gap);
        int hi = 0;
        int lo = 0;
        cong = 1'b1;
        step();
        while (carrier_o && hi < 20000) begin hi++; step(); end
        while (!carrier_o && lo < 20000) begin
            check("R5", int'(tx_grant_o), 0);
            lo++;
            step();
        end
        check(tag, hi, exp_car);
        check("R5", lo, exp_gap);
        cong = 1'b0;
        step();
    endtask

    initial begin
        #(4 * 200000);
        bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        if (!done) begin
            $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1", int'(carrier_o), 0);
        check("R1", int'(tx_grant_o), 1);

        for (int i = 0; i < 25; i++) begin
            {hd, bpen, cong, pend, coll} = VEC[i][6:2];
            step();
            check(rtag(VREQ[i]), int'(carrier_o), int'(VEC[i][1]));
            check(rtag(VREQ[i]), int'(tx_grant_o), int'(VEC[i][0]));
        end

        {hd, bpen, cong, pend, coll} = 5'b11000;
        clen = 16'd5; glen = 8'd3;
        step();
        measure("R4", 5, 3);
        clen = 16'd1; glen = 8'd1;
        measure("R4", 1, 1);
        clen = 16'd0; glen = 8'd0;
        measure("R6", 16000, 48);

        // frame pending during a gap takes the wire back at once
        clen = 16'd2; glen = 8'd4;
        cong = 1'b1;
        step(); step(); step();
        check("R5", int'(carrier_o), 0);
        pend = 1'b1;
        step();
        check("R7", int'(tx_grant_o), 1);
        pend = 1'b0;
        step();
        check("R8", int'(carrier_o), 1);
        step();
        check("R8", int'(carrier_o), 1);
        step();
        check("R8", int'(carrier_o), 0);

        // reset in the middle of a burst
        cong = 1'b0;
        step();
        cong = 1'b1;
        step();
        check("R3", int'(carrier_o), 1);
        rst = 1'b1;
        step();
        rst = 1'b0;
        cong = 1'b0;
        check("R1", int'(carrier_o), 0);
        check("R1", int'(tx_grant_o), 1);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end
endmodule